// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This block works out the program counter that follows a PC-relative conditional branch. It also produces the link-register write that a branch-and-link needs. It accepts short (16-bit) and long (32-bit) encodings. A short encoding carries an 8-bit immediate and a long one carries a 24-bit immediate. The immediate is sign-extended and doubled to form a halfword offset. Whether the condition holds is decided by a flag evaluator outside the block, which delivers a single pass bit. The block only uses that bit, except for the always-true code, where it ignores it.

One stimulus is presented per valid strobe. The results appear on registered outputs one clock later, together with an output valid pulse. A branch that is unconditional and has a zero offset would jump to itself forever. The block flags that case with an error strobe so the surrounding core can trap it.

Top module: `bru_nextpc_unit`

## Requirements
- R1: When the branch is taken, `next_pc` equals `cur_pc` plus the sign-extended immediate shifted left by one, modulo 2^32. Bit 0 of `next_pc` therefore equals bit 0 of `cur_pc`.
- R2: When `is_short` is 1, only `imm_field[7:0]` forms the immediate, with bit 7 as the sign, and `imm_field[23:8]` has no effect. When `is_short` is 0, all 24 bits are used, with bit 23 as the sign.
- R3: When the branch is not taken, `next_pc` equals `cur_pc` + 2 for a short encoding or `cur_pc` + 4 for a long one.
- R4: Condition code 4'h0 is always taken, whatever the value of `cond_pass`. Every other code is taken exactly when `cond_pass` is 1.
- R5: Condition code 4'hF raises `link_we` with `link_val` = `cur_pc` + 2 (short) or + 4 (long), independent of `cond_pass`. All other codes leave `link_we` at 0.
- R6: Condition code 4'h0 with a selected immediate of zero raises `selfloop_err`, and `next_pc` then equals `cur_pc`. For a short encoding, a nonzero `imm_field[23:8]` does not prevent the error.
- R7: Results are registered. `out_valid`, `link_we` and `selfloop_err` are valid in the cycle after the cycle in which `in_valid` was 1. They are low after any cycle with `in_valid` at 0, and `next_pc` holds its last value across such cycles.
- R8: While `rst_n` is low, `out_valid`, `link_we` and `selfloop_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Branch stimulus present this cycle |
| cur_pc | input | 32 | Address of the branch instruction |
| is_short | input | 1 | 1 = 16-bit encoding, 0 = 32-bit encoding |
| cond | input | 4 | Condition code |
| imm_field | input | 24 | Raw immediate; low 8 bits used for short encodings |
| cond_pass | input | 1 | Condition result from the external flag evaluator |
| out_valid | output | 1 | Result registers loaded from the previous cycle |
| next_pc | output | 32 | Following program counter |
| link_we | output | 1 | Link register write strobe |
| link_val | output | 32 | Return address for the link register |
| selfloop_err | output | 1 | Unconditional branch to itself detected |

## Verification
Each result is due exactly one clock edge after the strobe: `next_pc`, `link_we`, `link_val`, `selfloop_err` and `out_valid` are all loaded by the same register stage. The bench drives a stimulus on a falling edge and drops `in_valid` on the next falling edge. It compares every output there, half a period after the capturing rising edge. An idle cycle follows some transactions and is checked one falling edge later, to confirm that the strobes fall while `next_pc` holds.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned PC_W        = 32;
  localparam int unsigned COND_W      = 4;
  localparam int unsigned SHORT_IMM_W = 8;
  localparam int unsigned LONG_IMM_W  = 24;

  localparam logic [COND_W-1:0] COND_ALWAYS = 4'h0;
  localparam logic [COND_W-1:0] COND_LINK   = 4'hF;

  typedef struct packed {
    logic [PC_W-1:0] next_pc;
    logic            link_we;
    logic [PC_W-1:0] link_val;
    logic            selfloop;
  } bru_result_t;
endpackage

// File: rtl/bru_offset.sv
module bru_offset #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned SHORT_IMM_W = 8,
  parameter int unsigned LONG_IMM_W  = 24
) (
  input  logic                  is_short,
  input  logic [LONG_IMM_W-1:0] imm_field,
  output logic [PC_W-1:0]       offset,
  output logic                  imm_zero
);
  localparam int unsigned SHORT_PAD = PC_W - SHORT_IMM_W - 1;
  localparam int unsigned LONG_PAD  = PC_W - LONG_IMM_W - 1;

  logic [PC_W-1:0] short_off;
  logic [PC_W-1:0] long_off;

  // Halfword offsets: sign-extend, then append a zero LSB.
  always_comb begin
    short_off = {{SHORT_PAD{imm_field[SHORT_IMM_W-1]}}, imm_field[SHORT_IMM_W-1:0], 1'b0};
    long_off  = {{LONG_PAD{imm_field[LONG_IMM_W-1]}}, imm_field, 1'b0};
  end

  always_comb begin
    if (is_short) begin
      offset   = short_off;
      imm_zero = (imm_field[SHORT_IMM_W-1:0] == '0);
    end else begin
      offset   = long_off;
      imm_zero = (imm_field == '0);
    end
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              cond_pass,
  input  logic              imm_zero,
  output logic              taken,
  output logic              link,
  output logic              selfloop
);
  logic is_always;

  always_comb begin
    is_always = (cond == COND_ALWAYS);
    taken     = is_always | cond_pass;
    link      = (cond == COND_LINK);
    selfloop  = is_always & imm_zero;
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] cur_pc,
  input  logic            is_short,
  input  logic [PC_W-1:0] offset,
  input  logic            taken,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] next_pc
);
  logic [PC_W-1:0] step;
  logic [PC_W-1:0] branch_pc;

  always_comb begin
    step      = is_short ? PC_W'(2) : PC_W'(4);
    seq_pc    = cur_pc + step;
    branch_pc = cur_pc + offset;
    next_pc   = taken ? branch_pc : seq_pc;
  end
endmodule

// File: rtl/bru_nextpc_unit.sv
module bru_nextpc_unit
  import bru_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [PC_W-1:0]       cur_pc,
  input  logic                  is_short,
  input  logic [COND_W-1:0]     cond,
  input  logic [LONG_IMM_W-1:0] imm_field,
  input  logic                  cond_pass,
  output logic                  out_valid,
  output logic [PC_W-1:0]       next_pc,
  output logic                  link_we,
  output logic [PC_W-1:0]       link_val,
  output logic                  selfloop_err
);
  logic [PC_W-1:0] offset;
  logic            imm_zero;
  logic            taken;
  logic            link;
  logic            selfloop;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] target_pc;

  bru_result_t res_d;
  logic        valid_d;
  logic        link_we_d;
  logic        err_d;
  logic        valid_q;
  logic        link_we_q;
  logic        err_q;
  logic [PC_W-1:0] next_pc_q;
  logic [PC_W-1:0] link_val_q;

  bru_offset #(
    .PC_W       (PC_W),
    .SHORT_IMM_W(SHORT_IMM_W),
    .LONG_IMM_W (LONG_IMM_W)
  ) u_offset (
    .is_short (is_short),
    .imm_field(imm_field),
    .offset   (offset),
    .imm_zero (imm_zero)
  );

  bru_cond u_cond (
    .cond     (cond),
    .cond_pass(cond_pass),
    .imm_zero (imm_zero),
    .taken    (taken),
    .link     (link),
    .selfloop (selfloop)
  );

  bru_target #(.PC_W(PC_W)) u_target (
    .cur_pc  (cur_pc),
    .is_short(is_short),
    .offset  (offset),
    .taken   (taken),
    .seq_pc  (seq_pc),
    .next_pc (target_pc)
  );

  // Next-state logic
  always_comb begin
    res_d.next_pc  = target_pc;
    res_d.link_we  = link;
    res_d.link_val = seq_pc;
    res_d.selfloop = selfloop;
    valid_d        = in_valid;
    link_we_d      = in_valid & res_d.link_we;
    err_d          = in_valid & res_d.selfloop;
  end

  // Control registers: asynchronous reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      link_we_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      link_we_q <= link_we_d;
      err_q     <= err_d;
    end
  end

  // Datapath registers: no reset, loaded under clock enable
  always_ff @(posedge clk) begin
    if (in_valid) begin
      next_pc_q  <= res_d.next_pc;
      link_val_q <= res_d.link_val;
    end
  end

  assign out_valid    = valid_q;
  assign link_we      = link_we_q;
  assign selfloop_err = err_q;
  assign next_pc      = next_pc_q;
  assign link_val     = link_val_q;
endmodule

// File: rtl/bru_nextpc_chk.sv
module bru_nextpc_chk
  import bru_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [PC_W-1:0]       cur_pc,
  input logic                  is_short,
  input logic [COND_W-1:0]     cond,
  input logic [LONG_IMM_W-1:0] imm_field,
  input logic                  cond_pass,
  input logic                  out_valid,
  input logic [PC_W-1:0]       next_pc,
  input logic                  link_we,
  input logic [PC_W-1:0]       link_val,
  input logic                  selfloop_err
);
  logic sel_zero;
  assign sel_zero = is_short ? (imm_field[SHORT_IMM_W-1:0] == '0) : (imm_field == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !link_we && !selfloop_err)); // R7

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond != COND_ALWAYS && !cond_pass) |=>
      next_pc == $past(cur_pc) + ($past(is_short) ? 32'd2 : 32'd4)); // R3

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == COND_LINK) |=>
      (link_we && link_val == $past(cur_pc) + ($past(is_short) ? 32'd2 : 32'd4))); // R5

  AST_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond != COND_LINK) |=> !link_we); // R5

  AST_SELF_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == COND_ALWAYS && sel_zero) |=>
      (selfloop_err && next_pc == $past(cur_pc))); // R6

  AST_HALFWORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> next_pc[0] == $past(cur_pc[0])); // R1

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_valid && !link_we && !selfloop_err); // R8
    end
  end
endmodule

bind bru_nextpc_unit bru_nextpc_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .cur_pc      (cur_pc),
  .is_short    (is_short),
  .cond        (cond),
  .imm_field   (imm_field),
  .cond_pass   (cond_pass),
  .out_valid   (out_valid),
  .next_pc     (next_pc),
  .link_we     (link_we),
  .link_val    (link_val),
  .selfloop_err(selfloop_err)
);

// File: tb/sim_bru_nextpc_unit.sv
`timescale 1ns/1ps
module sim_bru_nextpc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] cur_pc;
  logic        is_short;
  logic [3:0]  cond;
  logic [23:0] imm_field;
  logic        cond_pass;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        link_we;
  logic [31:0] link_val;
  logic        selfloop_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  bru_nextpc_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
    .is_short(is_short), .cond(cond), .imm_field(imm_field),
    .cond_pass(cond_pass), .out_valid(out_valid), .next_pc(next_pc),
    .link_we(link_we), .link_val(link_val), .selfloop_err(selfloop_err)
  );

  function automatic logic [31:0] f_offset(input logic s, input logic [23:0] imm);
    logic signed [31:0] v;
    if (s) v = 32'(signed'(imm[7:0]));
    else   v = 32'(signed'(imm));
    return 32'(v) << 1;
  endfunction

  function automatic logic f_taken(input logic [3:0] c, input logic p);
    return (c == 4'h0) ? 1'b1 : p;
  endfunction

  function automatic logic [31:0] f_next(input logic [31:0] pc, input logic s,
      input logic [3:0] c, input logic [23:0] imm, input logic p);
    if (f_taken(c, p)) return pc + f_offset(s, imm);
    return pc + (s ? 32'd2 : 32'd4);
  endfunction

  function automatic logic f_err(input logic s, input logic [3:0] c, input logic [23:0] imm);
    return (c == 4'h0) && (s ? (imm[7:0] == 8'h0) : (imm == 24'h0));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] pc, input logic s, input logic [3:0] c,
                     input logic [23:0] imm, input logic p, input bit idle_after);
    logic [31:0] exp_pc;
    cur_pc = pc; is_short = s; cond = c; imm_field = imm; cond_pass = p;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_pc = f_next(pc, s, c, imm, p);
    chk("R7 out_valid", 32'(out_valid), 32'd1);
    if (f_taken(c, p)) chk(s ? "R1/R2 taken next_pc short" : "R1 taken next_pc long", next_pc, exp_pc);
    else               chk("R3 not-taken next_pc", next_pc, exp_pc);
    chk("R5 link_we", 32'(link_we), 32'(c == 4'hF));
    if (c == 4'hF) chk("R5 link_val", link_val, pc + (s ? 32'd2 : 32'd4));
    chk("R6 selfloop_err", 32'(selfloop_err), 32'(f_err(s, c, imm)));
    if (idle_after) begin
      cur_pc = ~pc; cond = 4'hF; imm_field = 24'h0;
      @(negedge clk);
      chk("R7 idle strobes", {29'd0, out_valid, link_we, selfloop_err}, 32'd0);
      chk("R7 idle next_pc hold", next_pc, exp_pc);
    end
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    rst_n = 1'b0; in_valid = 1'b0; cur_pc = '0; is_short = 1'b0;
    cond = '0; imm_field = '0; cond_pass = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", 32'(out_valid), 32'd0);
    chk("R8 reset link_we", 32'(link_we), 32'd0);
    chk("R8 reset selfloop_err", 32'(selfloop_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run(32'h0000_1000, 1'b1, 4'h3, 24'h000080, 1'b1, 1'b1); // R2 most negative short
    run(32'h0000_1000, 1'b1, 4'h3, 24'hFFFF05, 1'b1, 1'b0); // R2 upper bits ignored
    run(32'h0100_0000, 1'b0, 4'h7, 24'h800000, 1'b1, 1'b0); // R1 most negative long
    run(32'hFFFF_FFFE, 1'b0, 4'h2, 24'h000010, 1'b1, 1'b0); // R1 wrap
    run(32'hFFFF_FFFE, 1'b1, 4'h2, 24'h000010, 1'b0, 1'b0); // R3 wrap short
    run(32'h0000_2000, 1'b0, 4'h0, 24'h000040, 1'b0, 1'b0); // R4 always ignores pass
    run(32'h0000_3000, 1'b1, 4'hF, 24'h000010, 1'b0, 1'b1); // R5 link not taken
    run(32'h0000_3000, 1'b0, 4'hF, 24'hFFFFF0, 1'b1, 1'b0); // R5 link taken
    run(32'h0000_4004, 1'b1, 4'h0, 24'hAB0000, 1'b0, 1'b1); // R6 short self-loop
    run(32'h0000_4008, 1'b0, 4'h0, 24'h000000, 1'b1, 1'b0); // R6 long self-loop
    run(32'h0000_4008, 1'b0, 4'h0, 24'h000100, 1'b1, 1'b0); // R6 long nonzero: no error
    run(32'h0000_5000, 1'b0, 4'h9, 24'h000000, 1'b0, 1'b0); // R3 zero imm other cond

    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      logic [23:0] imm;
      int sel;
      sel = $urandom_range(0, 3);
      c   = (sel == 0) ? 4'h0 : (sel == 1) ? 4'hF : 4'($urandom);
      imm = ($urandom_range(0, 7) == 0) ? 24'h0 : 24'($urandom);
      run({$urandom} & 32'hFFFF_FFFE, 1'($urandom), c, imm, 1'($urandom),
          ($urandom_range(0, 4) == 0));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule